// File: doc/BRIEF.md
# Serial EEPROM Host Sequencer (three-wire, 128 x 16)

This block sits between a simple command interface and a three-wire serial EEPROM organised as 128 words of 16 bits. A client presents an operation, a 7-bit word address, 16 bits of write data and a wrap flag while `reqReady` is high. The block then drives chip select, the serial clock and the serial data line, and samples the EEPROM's data output. When the transaction ends it raises `rspDone` for one cycle, with the captured read word on `rspData` and an error flag on `rspErr`.

Every instruction is framed as a start bit, a two-bit opcode and an eight-bit field, all sent MSB first. The field carries the word address, or a mode code for the operations that do not address a word. Program operations are closed by releasing chip select. The block then keeps chip select low for a set deselect time and raises it again. It holds the clock and data lines low and watches the data output until the EEPROM reports ready, or until a timeout expires. With the wrap flag set, a program operation is bracketed by an enable instruction before it and a disable instruction after it.

All serial timing is set in clock cycles by parameters: the clock half period, the deselect time and the busy timeout. The defaults suit a 200 MHz system clock, which gives a 1 MHz serial clock, 250 ns of deselect and a 10 ms timeout.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, chip select, serial clock and `rspDone` are low and `reqReady` is high.
- R2: Each instruction starts with a 1, then a two-bit opcode, then an eight-bit field whose low seven bits are the word address with bit 7 at 0, all MSB first. The data line only changes while the serial clock is low. Opcodes are: read 10, write 01, erase 11.
- R3: Operations without an address send opcode 00, and the top two field bits select the mode: 11 enable, 00 disable, 01 fill all, 10 erase all. The remaining field bits are sent as 0.
- R4: Write and fill-all send 16 data bits MSB first after the field. Chip select falls on the same clock edge as the final serial clock fall, with no further rising clock edge.
- R5: A read clocks 16 slots after the field and captures the data output at the end of each high phase. This skips the dummy 0, and the 16-bit word is returned on `rspData` with `rspDone`.
- R6: Each serial clock phase inside an instruction lasts at least `SK_HALF` system clocks.
- R7: Chip select stays low for at least `CS_LOW` clocks before every rise.
- R8: After a program instruction, chip select is raised with the serial clock and data lines low. The block samples the data output each clock, treating 0 as busy and 1 as ready. On ready it ends with `rspErr` low.
- R9: If ready is not seen within `TIMEOUT` clocks of polling, the operation ends with `rspDone` and `rspErr` high, and chip select is released.
- R10: With `reqWrap` set on a program operation, the sequence is enable, then the operation with its poll, then disable. Without it, only the requested instruction is sent.
- R11: `reqReady` is high only while idle. A request presented while busy is not taken and produces no instruction.
- R12: `rspDone` is a single-cycle pulse. `reqOp` encoding: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 fill all, 6 erase all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 3 | Operation code (see R12) |
| reqWrap | input | 1 | Bracket program operations with enable and disable |
| reqAddr | input | 7 | Word address |
| reqData | input | 16 | Write or fill data |
| reqReady | output | 1 | Idle, request will be taken |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Busy timeout occurred in the last operation |
| rspData | output | 16 | Word captured by the last read |
| csOut | output | 1 | EEPROM chip select, active high |
| skOut | output | 1 | Serial clock |
| dinOut | output | 1 | Serial data to the EEPROM |
| doutIn | input | 1 | Serial data and ready status from the EEPROM |

## Verification
At the end of a frame, the last shift or read capture and the release of chip select fall on the same clock edge. If either is dropped or moved by one cycle, the final bit is lost. The bench drives this with a read whose word has its least significant bit set, and with writes whose last data bit is 1. It judges the result from the full returned word and from the bit count the EEPROM model logs at chip-select fall, which must be exactly 10 or 26 bits after the start bit.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WEN   = 3'd3,
    OP_WDS   = 3'd4,
    OP_WRALL = 3'd5,
    OP_ERAL  = 3'd6
  } mwOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // take request fields
    logic load;     // build frame into shifter
    logic shift;    // advance shifter one bit
    logic capture;  // shift doutIn into read word
    logic dinEn;    // present shifter MSB on dinOut
  } mwStrb_t;

  function automatic logic isProgram(mwOp_e op);
    return op inside {OP_WRITE, OP_ERASE, OP_WRALL, OP_ERAL};
  endfunction

  function automatic logic hasPayload(mwOp_e op);
    return op inside {OP_READ, OP_WRITE, OP_WRALL};
  endfunction

endpackage

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwStrb_t           strb,
  input  mwOp_e             frameOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              doutIn,
  output logic              dinOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int FIELD_W = ADDR_W + 1;
  localparam int HDR_W   = 3 + FIELD_W;
  localparam int FRAME_W = HDR_W + DATA_W;

  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  dataQ;
  logic [FRAME_W-1:0] shiftQ;
  logic [DATA_W-1:0]  rdQ;

  logic [1:0]         opc;
  logic [FIELD_W-1:0] field;
  logic [DATA_W-1:0]  payload;

  localparam logic [FIELD_W-3:0] PAD = '0;

  always_comb begin
    opc     = 2'b00;
    field   = '0;
    payload = '0;
    case (frameOp)
      OP_READ:  begin opc = 2'b10; field = {1'b0, addrQ}; end
      OP_WRITE: begin opc = 2'b01; field = {1'b0, addrQ}; payload = dataQ; end
      OP_ERASE: begin opc = 2'b11; field = {1'b0, addrQ}; end
      OP_WEN:   field = {2'b11, PAD};
      OP_WDS:   field = {2'b00, PAD};
      OP_WRALL: begin field = {2'b01, PAD}; payload = dataQ; end
      OP_ERAL:  field = {2'b10, PAD};
      default:  field = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      shiftQ <= '0;
      rdQ    <= '0;
    end else begin
      if (strb.latch) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
      end
      if (strb.load)
        shiftQ <= {1'b1, opc, field, payload};
      else if (strb.shift)
        shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
      if (strb.capture)
        rdQ <= {rdQ[DATA_W-2:0], doutIn};
    end
  end

  assign dinOut = strb.dinEn & shiftQ[FRAME_W-1];
  assign rdData = rdQ;

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int SK_HALF = 100,
  parameter int CS_LOW  = 50,
  parameter int TIMEOUT = 2000000,
  parameter int HDR_W   = 11,
  parameter int FRAME_W = 27
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       reqWrap,
  input  logic       doutIn,
  output logic       reqReady,
  output mwOp_e      frameOp,
  output mwStrb_t    strb,
  output logic       csOut,
  output logic       skOut,
  output logic       rspDone,
  output logic       rspErr
);

  localparam int LIM1  = (SK_HALF > CS_LOW) ? SK_HALF : CS_LOW;
  localparam int LIMIT = (TIMEOUT > LIM1) ? TIMEOUT : LIM1;
  localparam int TW    = $clog2(LIMIT + 1);
  localparam int BW    = $clog2(FRAME_W + 1);
  localparam int LW    = $clog2(CS_LOW + 1);
  localparam int SW    = $clog2(SK_HALF + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SKLO, S_SKHI, S_DESEL, S_POLL, S_DONE
  } state_e;

  state_e        state;
  logic [TW-1:0] timer;
  logic [BW-1:0] bitCnt;
  logic [1:0]    step;     // 0 enable, 1 main, 2 disable
  mwOp_e         mainOp;
  logic          wrapQ;
  logic          polled;
  logic          errQ;

  logic [BW-1:0] nBits;
  logic          halfEnd;

  always_comb begin
    if (step == 2'd0)      frameOp = OP_WEN;
    else if (step == 2'd2) frameOp = OP_WDS;
    else                   frameOp = mainOp;
    nBits   = hasPayload(frameOp) ? BW'(FRAME_W) : BW'(HDR_W);
    halfEnd = (timer == TW'(SK_HALF - 1));

    strb         = '0;
    strb.latch   = (state == S_IDLE) && reqValid;
    strb.load    = (state == S_LOAD);
    strb.dinEn   = (state == S_SKLO) || (state == S_SKHI);
    strb.shift   = (state == S_SKHI) && halfEnd;
    strb.capture = (state == S_SKHI) && halfEnd && (frameOp == OP_READ)
                   && (bitCnt >= BW'(HDR_W));
  end

  assign reqReady = (state == S_IDLE);
  assign csOut    = (state == S_SKLO) || (state == S_SKHI) || (state == S_POLL);
  assign skOut    = (state == S_SKHI);
  assign rspDone  = (state == S_DONE);
  assign rspErr   = errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      timer  <= '0;
      bitCnt <= '0;
      step   <= 2'd1;
      mainOp <= OP_READ;
      wrapQ  <= 1'b0;
      polled <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          mainOp <= mwOp_e'(reqOp);
          wrapQ  <= reqWrap && isProgram(mwOp_e'(reqOp));
          step   <= (reqWrap && isProgram(mwOp_e'(reqOp))) ? 2'd0 : 2'd1;
          errQ   <= 1'b0;
          polled <= 1'b0;
          state  <= S_LOAD;
        end
        S_LOAD: begin
          timer  <= '0;
          bitCnt <= '0;
          state  <= S_SKLO;
        end
        S_SKLO: begin
          timer <= halfEnd ? '0 : timer + TW'(1);
          if (halfEnd) state <= S_SKHI;
        end
        S_SKHI: begin
          timer <= halfEnd ? '0 : timer + TW'(1);
          if (halfEnd) begin
            bitCnt <= bitCnt + BW'(1);
            state  <= (bitCnt == nBits - BW'(1)) ? S_DESEL : S_SKLO;
          end
        end
        S_DESEL: begin
          timer <= timer + TW'(1);
          if (timer == TW'(CS_LOW - 1)) begin
            timer <= '0;
            if (errQ) state <= S_DONE;
            else if (isProgram(frameOp) && !polled) state <= S_POLL;
            else if (step == 2'd0) begin
              step <= 2'd1; polled <= 1'b0; state <= S_LOAD;
            end else if (step == 2'd1 && wrapQ) begin
              step <= 2'd2; polled <= 1'b0; state <= S_LOAD;
            end else state <= S_DONE;
          end
        end
        S_POLL: begin
          timer <= timer + TW'(1);
          if (doutIn) begin
            polled <= 1'b1; timer <= '0; state <= S_DESEL;
          end else if (timer == TW'(TIMEOUT - 1)) begin
            errQ <= 1'b1; timer <= '0; state <= S_DESEL;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // checker state: lengths of chip-select low runs and clock phases
  logic [LW-1:0] lowRun;
  logic [SW-1:0] skRun;
  logic          csPrev, skPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= LW'(CS_LOW);
      skRun  <= SW'(SK_HALF);
      csPrev <= 1'b0;
      skPrev <= 1'b0;
    end else begin
      csPrev <= csOut;
      skPrev <= skOut;
      if (csOut) lowRun <= '0;
      else if (lowRun != LW'(CS_LOW)) lowRun <= lowRun + LW'(1);
      if (skOut != skPrev) skRun <= SW'(1);
      else if (skRun != SW'(SK_HALF)) skRun <= skRun + SW'(1);
    end
  end

  // R7
  cs_low_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csOut && !csPrev) |-> (lowRun >= LW'(CS_LOW)));

  // R6
  sk_phase_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csOut && csPrev && (skOut != skPrev)) |-> (skRun >= SW'(SK_HALF)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int SK_HALF = 100,
  parameter int CS_LOW  = 50,
  parameter int TIMEOUT = 2000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic              reqWrap,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              rspDone,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic              csOut,
  output logic              skOut,
  output logic              dinOut,
  input  logic              doutIn
);

  localparam int HDR_W   = ADDR_W + 4;
  localparam int FRAME_W = HDR_W + DATA_W;

  mwStrb_t strb;
  mwOp_e   frameOp;

  mw_ctrl #(
    .SK_HALF(SK_HALF), .CS_LOW(CS_LOW), .TIMEOUT(TIMEOUT),
    .HDR_W(HDR_W), .FRAME_W(FRAME_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqWrap(reqWrap), .doutIn(doutIn), .reqReady(reqReady),
    .frameOp(frameOp), .strb(strb), .csOut(csOut), .skOut(skOut),
    .rspDone(rspDone), .rspErr(rspErr)
  );

  mw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .frameOp(frameOp),
    .reqAddr(reqAddr), .reqData(reqData), .doutIn(doutIn),
    .dinOut(dinOut), .rdData(rspData)
  );

  // R2
  din_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skOut && $past(skOut)) |-> $stable(dinOut));

endmodule

// File: tb/sim_mw_eeprom_host.sv
`timescale 1ns/1ps
module sim_mw_eeprom_host;

  localparam int SKH = 2, CSL = 4, TMO = 300, BUSY = 40;
  localparam logic [2:0] C_READ = 3'd0, C_WRITE = 3'd1, C_ERASE = 3'd2,
    C_WEN = 3'd3, C_WDS = 3'd4, C_WRALL = 3'd5, C_ERAL = 3'd6;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrap = 1'b0, doutIn = 1'b0;
  logic [2:0] reqOp = '0;
  logic [6:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic reqReady, rspDone, rspErr, csOut, skOut, dinOut;
  logic [15:0] rspData;

  always #2.5 clk = ~clk;

  mw_eeprom_host #(.SK_HALF(SKH), .CS_LOW(CSL), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqWrap(reqWrap), .reqAddr(reqAddr), .reqData(reqData),
    .reqReady(reqReady), .rspDone(rspDone), .rspErr(rspErr),
    .rspData(rspData), .csOut(csOut), .skOut(skOut), .dinOut(dinOut),
    .doutIn(doutIn)
  );

  int nChk = 0, nFail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [15:0] mem [128];
  logic we = 0, started = 0, rdMode = 0, pollWin = 0, stuck = 0;
  logic prevSk = 0, prevCs = 0, doutQ = 0;
  int cnt = 0, busyCnt = 0;
  logic [25:0] sh = '0;
  logic [15:0] rdSh = '0;
  logic [9:0] logHdr [64];
  int logCnt [64];
  int nLog = 0, pollBad = 0;
  int skRun = 1, csLowRun = 1000, minSk = 1000, minCsLow = 1000;

  task automatic mdlDecode();
    logic [9:0] hdr;
    logic [15:0] dat;
    hdr = (cnt == 26) ? sh[25:16] : sh[9:0];
    dat = sh[15:0];
    if (nLog < 64) begin logHdr[nLog] = hdr; logCnt[nLog] = cnt; end
    nLog++;
    case (hdr[9:8])
      2'b01: begin
        if (we && cnt == 26) mem[hdr[6:0]] = dat;
        pollWin = 1; busyCnt = we ? BUSY : 0;
      end
      2'b11: begin
        if (we) mem[hdr[6:0]] = 16'hFFFF;
        pollWin = 1; busyCnt = we ? BUSY : 0;
      end
      2'b00: case (hdr[7:6])
        2'b11: we = 1;
        2'b00: we = 0;
        2'b01: begin
          if (we && cnt == 26) for (int i = 0; i < 128; i++) mem[i] = dat;
          pollWin = 1; busyCnt = we ? BUSY : 0;
        end
        default: begin
          if (we) for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;
          pollWin = 1; busyCnt = we ? BUSY : 0;
        end
      endcase
      default: ;
    endcase
  endtask

  initial for (int i = 0; i < 128; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (busyCnt > 0) busyCnt--;
    if (csOut && prevCs && skOut && !prevSk) begin
      if (!started) begin
        if (dinOut) begin started = 1; cnt = 0; end
      end else begin
        sh = {sh[24:0], dinOut};
        cnt++;
        if (rdMode) begin doutQ = rdSh[15]; rdSh = {rdSh[14:0], 1'b0}; end
        else if (cnt == 10 && sh[9:8] == 2'b10) begin
          rdMode = 1; rdSh = mem[sh[6:0]]; doutQ = 0;
        end
      end
    end
    if (!csOut && prevCs) begin
      if (pollWin && !started) pollWin = 0;
      else if (started) mdlDecode();
      started = 0; rdMode = 0;
    end
    if (csOut && pollWin && !started && (skOut || dinOut)) pollBad++;
    // phase and deselect lengths
    if (csOut && prevCs) begin
      if (skOut != prevSk) begin
        if (skRun < minSk) minSk = skRun;
        skRun = 1;
      end else skRun++;
    end else skRun = 1;
    if (!csOut) csLowRun++;
    else if (!prevCs) begin
      if (csLowRun < minCsLow) minCsLow = csLowRun;
      csLowRun = 0;
    end
    doutIn = !csOut ? 1'b0 : rdMode ? doutQ :
             pollWin ? (busyCnt == 0 && !stuck) : 1'b0;
    prevSk = skOut; prevCs = csOut;
  end

  // ---------------- command driver ----------------
  logic [15:0] lastRd;
  logic lastErr;

  task automatic runCmd(input logic [2:0] op, input logic wrap,
                        input logic [6:0] addr, input logic [15:0] data);
    int guard;
    @(negedge clk);
    reqValid = 1; reqOp = op; reqWrap = wrap; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqValid = 0;
    guard = 0;
    while (!rspDone && guard < 20000) begin @(negedge clk); guard++; end
    lastRd = rspData; lastErr = rspErr;
    @(negedge clk);
    check("R12 done pulse width", {31'd0, rspDone}, 32'd0);
  endtask

  task automatic tReset();
    check("R1 cs low", {31'd0, csOut}, 0);
    check("R1 sk low", {31'd0, skOut}, 0);
    check("R1 ready high", {31'd0, reqReady}, 1);
    check("R1 done low", {31'd0, rspDone}, 0);
  endtask

  task automatic tEnable();
    int b = nLog;
    runCmd(C_WEN, 0, 7'h00, 16'h0);
    check("R3 enable header", {22'd0, logHdr[b]}, 32'h0C0);
    check("R3 enable bit count", logCnt[b], 10);
    check("R3 enable single frame", nLog - b, 1);
  endtask

  task automatic tWrite();
    int b = nLog;
    runCmd(C_WRITE, 0, 7'h5A, 16'hBEEF);
    check("R2 write header", {22'd0, logHdr[b]}, 32'h15A);
    check("R4 write bit count", logCnt[b], 26);
    check("R4 write data in memory", {16'd0, mem[7'h5A]}, 32'hBEEF);
    check("R8 write no error", {31'd0, lastErr}, 0);
    check("R8 poll lines quiet", pollBad, 0);
  endtask

  task automatic tRead(input logic [6:0] a, input logic [15:0] exp, input string tag);
    int b = nLog;
    runCmd(C_READ, 0, a, 16'h0);
    check({tag, " read word"}, {16'd0, lastRd}, {16'd0, exp});
    check("R2 read header", {22'd0, logHdr[b]}, {22'd0, 2'b10, 1'b0, a});
  endtask

  task automatic tErase();
    int b = nLog;
    runCmd(C_ERASE, 0, 7'h5A, 16'h0);
    check("R2 erase header", {22'd0, logHdr[b]}, 32'h35A);
    tRead(7'h5A, 16'hFFFF, "R5 after erase");
  endtask

  task automatic tDisable();
    int b = nLog;
    runCmd(C_WDS, 0, 7'h00, 16'h0);
    check("R3 disable header", {22'd0, logHdr[b]}, 32'h000);
    runCmd(C_WRITE, 0, 7'h5A, 16'h1111);
    tRead(7'h5A, 16'hFFFF, "R5 protected");
  endtask

  task automatic tWrapFill();
    int b = nLog;
    runCmd(C_WRALL, 1, 7'h00, 16'h1235);
    check("R10 wrap frame count", nLog - b, 3);
    check("R10 first is enable", {22'd0, logHdr[b]}, 32'h0C0);
    check("R3 fill header", {22'd0, logHdr[b+1]}, 32'h040);
    check("R4 fill bit count", logCnt[b+1], 26);
    check("R10 last is disable", {22'd0, logHdr[b+2]}, 32'h000);
    check("R10 left protected", {31'd0, we}, 0);
    tRead(7'h07, 16'h1235, "R5 after fill");
  endtask

  task automatic tWrapEraseAll();
    int b = nLog;
    runCmd(C_ERAL, 1, 7'h00, 16'h0);
    check("R3 erase-all header", {22'd0, logHdr[b+1]}, 32'h080);
    check("R10 erase-all wrapped", nLog - b, 3);
    tRead(7'h33, 16'hFFFF, "R5 after erase-all");
  endtask

  task automatic tBusyIgnore();
    int b = nLog;
    int notReady = 0;
    @(negedge clk);
    reqValid = 1; reqOp = C_WRITE; reqWrap = 0; reqAddr = 7'h10; reqData = 16'h0A0A;
    @(negedge clk);
    reqOp = C_WEN;
    for (int i = 0; i < 30; i++) begin
      if (!reqReady) notReady++;
      @(negedge clk);
    end
    reqValid = 0;
    while (!rspDone) @(negedge clk);
    @(negedge clk);
    check("R11 ready low while busy", notReady, 30);
    check("R11 one frame only", nLog - b, 1);
    check("R11 frame is the write", {22'd0, logHdr[b]}, 32'h110);
    check("R11 enable not sent", {31'd0, we}, 0);
  endtask

  task automatic tTimeout();
    stuck = 1;
    runCmd(C_ERASE, 0, 7'h01, 16'h0);
    check("R9 error flag", {31'd0, lastErr}, 1);
    check("R9 cs released", {31'd0, csOut}, 0);
    stuck = 0;
    runCmd(C_ERASE, 0, 7'h01, 16'h0);
    check("R8 error cleared on ready", {31'd0, lastErr}, 0);
  endtask

  task automatic tTiming();
    check("R6 min clock phase", (minSk >= SKH) ? 1 : 0, 1);
    check("R7 min deselect", (minCsLow >= CSL) ? 1 : 0, 1);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    repeat (2) @(negedge clk);
    tEnable();
    tWrite();
    tRead(7'h5A, 16'hBEEF, "R5");
    tErase();
    tDisable();
    tWrapFill();
    tWrapEraseAll();
    tBusyIgnore();
    tTimeout();
    tTiming();
    finishRun();
  end

endmodule